// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indication

This block sits between the two programmable dividers of a PLL frequency synthesizer and the loop filter. It takes the divided reference stream and the divided oscillator stream and compares their rising edges. From that comparison it produces the loop-error information in two forms and a lock flag. Both inputs are asynchronous to the sampling clock. Each is first brought into the clock domain, and a rising-edge pulse is made from it.

Inside, a two-flag state machine records which stream has shown a rising edge since the last reset of the flags. Once both flags are set, a short timer holds them for a fixed number of clocks and then clears them together. When the two streams match, this produces a brief coincident pulse on both active-low outputs. The single-ended output is derived from the same flags. It is given as a drive value plus an output enable, so that a pad or a charge-pump switch pair can be driven directly. The lock flag is low only while exactly one error output is active.

Top module: `pfd_lock_top`

## Requirements
- R1: A rising edge on either input reaches its flag at the (SYNC_STAGES+1)-th rising clock edge after the input change is set up. With the default of 2, that is the third edge. The internal edge pulse lasts exactly one clock.
- R2: While the oscillator flag is set and the reference flag is not, the outputs are: pd_oe=1, pd_drive=0 (negative pulse), phi_v_n=0 and phi_r_n=1. This is the case when the oscillator stream is faster or leads.
- R3: While the reference flag is set and the oscillator flag is not, the outputs are: pd_oe=1, pd_drive=1 (positive pulse), phi_r_n=0 and phi_v_n=1. This is the case when the oscillator stream is slower or lags.
- R4: With equal frequencies and coincident edges, pd_oe stays 0 (high impedance) throughout. phi_r_n and phi_v_n go low together.
- R5: Once both flags are set, both active-low outputs stay low for exactly MIN_PULSE clocks (default 2). Then both return high.
- R6: With equal frequencies and the oscillator leading by d clocks, each negative pulse on the single-ended output lasts exactly d clocks.
- R7: lock is 1 when phi_r_n equals phi_v_n. It is 0 while exactly one of them is low.
- R8: A synchronous active-low reset clears both flags and the synchronizers. The reset state is phi_r_n=1, phi_v_n=1, pd_oe=0 and lock=1.
- R9: An edge that arrives on the same clock as the coincident pulse ends sets its flag again on that clock. The edge is not lost. An edge that arrives while its flag is already set has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Divided reference stream, asynchronous |
| vco_in | input | 1 | Divided oscillator stream, asynchronous |
| pd_drive | output | 1 | Single-ended error level, valid when pd_oe is 1 |
| pd_oe | output | 1 | Single-ended output enable (0 means high impedance) |
| phi_r_n | output | 1 | Active-low pulse while the reference is ahead |
| phi_v_n | output | 1 | Active-low pulse while the oscillator is ahead |
| lock | output | 1 | High in lock, low while one error output pulses |

## Verification
The hardest case to reach is a new edge landing on the exact clock where the coincident pulse ends. There, the re-arming rule of R9 decides whether the edge is kept or dropped. Equal-frequency directed cases alone never produce it. Random cases therefore pick two periods that differ by a few clocks and a random phase offset, so the edge positions drift across the clearing window over many periods. A cycle-level model in the bench follows the same rules, and all outputs are compared against it on every clock.

// File: rtl/pfd_pkg.sv
// Package: shared constants and helpers for the phase-frequency detector.
// Assumes: two input channels, reference first.
package pfd_pkg;
    localparam int CH_REF = 0;
    localparam int CH_VCO = 1;
    localparam int N_CH   = 2;

    // single-ended output as drive level plus enable
    typedef struct packed {
        logic drive;
        logic oe;
    } se_out_t;

    // counter width that is at least one bit
    function automatic int cnt_width(input int limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction
endpackage

// File: rtl/pfd_edge_sync.sv
// Module: pfd_edge_sync
// Brings one asynchronous level into the clock domain through STAGES flops
// and produces a one-clock pulse on each rising edge.
// Assumes: STAGES >= 2; the input is held long enough to be sampled.
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic [STAGES:0] pipe_q;

    // shift the input through the synchronizer plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-1:0], async_in};
        end
    end

    // rising edge seen between the last synchronized stage and its history
    always_comb begin
        rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    end

    // R1
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/pfd_core.sv
// Module: pfd_core
// Two-flag edge state machine. A reference edge sets ref_seen and an
// oscillator edge sets vco_seen. When both are set, a timer holds them for
// MIN_PULSE clocks and then clears both. An edge arriving on the clearing
// clock sets its flag again.
// Assumes: edge inputs are single-clock pulses; MIN_PULSE >= 1.
module pfd_core
    import pfd_pkg::*;
#(
    parameter int MIN_PULSE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_ref,
    input  logic rise_vco,
    output logic ref_seen,
    output logic vco_seen
);
    localparam int CW = cnt_width(MIN_PULSE);
    localparam logic [CW-1:0] LAST = CW'(MIN_PULSE - 1);

    logic [CW-1:0] hold_q;
    logic          both;
    logic          release_now;

    // both flags up, and whether this clock ends the coincident pulse
    always_comb begin
        both        = ref_seen & vco_seen;
        release_now = both && (hold_q == LAST);
    end

    // flag update: set on edges, clear together after the hold time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_seen <= 1'b0;
            vco_seen <= 1'b0;
        end else if (release_now) begin
            ref_seen <= rise_ref;
            vco_seen <= rise_vco;
        end else if (!both) begin
            ref_seen <= ref_seen | rise_ref;
            vco_seen <= vco_seen | rise_vco;
        end
    end

    // hold timer: counts clocks while both flags are set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (both && !release_now) begin
            hold_q <= hold_q + 1'b1;
        end else begin
            hold_q <= '0;
        end
    end

    // R5
    hold_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q <= LAST);

    generate
        if (MIN_PULSE > 1) begin : g_hold_check
            // R5
            coincident_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (both && hold_q == '0) |=> (ref_seen && vco_seen));
        end
    endgenerate
endmodule

// File: rtl/pfd_drive.sv
// Module: pfd_drive
// Decodes the two flags into the single-ended three-state output, the
// active-low pair and the lock flag. Purely combinational.
// Assumes: flags come straight from registers, so outputs are glitch-free.
module pfd_drive
    import pfd_pkg::*;
(
    input  logic ref_seen,
    input  logic vco_seen,
    output se_out_t se_o,
    output logic phi_r_n,
    output logic phi_v_n,
    output logic lock_o
);
    // active-low pair follows each flag
    always_comb begin
        phi_r_n = ~ref_seen;
        phi_v_n = ~vco_seen;
    end

    // single-ended: enabled when exactly one side is ahead; high when reference leads
    always_comb begin
        se_o.oe    = ref_seen ^ vco_seen;
        se_o.drive = ref_seen & ~vco_seen;
    end

    // lock: both outputs agree
    always_comb begin
        lock_o = ~(phi_r_n ^ phi_v_n);
    end
endmodule

// File: rtl/pfd_lock_top.sv
// Module: pfd_lock_top
// Phase-frequency detector with three-state single-ended output, active-low
// double-ended outputs and lock flag, all from one flag state machine.
// Assumes: ref_in and vco_in are asynchronous, slower than clk/2.
module pfd_lock_top
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_PULSE   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic vco_in,
    output logic pd_drive,
    output logic pd_oe,
    output logic phi_r_n,
    output logic phi_v_n,
    output logic lock
);
    logic [N_CH-1:0] raw_in;
    logic [N_CH-1:0] rise;
    logic            ref_seen;
    logic            vco_seen;
    se_out_t         se;

    // gather the inputs into channel order
    always_comb begin
        raw_in[CH_REF] = ref_in;
        raw_in[CH_VCO] = vco_in;
    end

    generate
        for (genvar ch = 0; ch < N_CH; ch++) begin : g_sync
            pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .async_in (raw_in[ch]),
                .rise_o   (rise[ch])
            );
        end
    endgenerate

    pfd_core #(.MIN_PULSE(MIN_PULSE)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_ref (rise[CH_REF]),
        .rise_vco (rise[CH_VCO]),
        .ref_seen (ref_seen),
        .vco_seen (vco_seen)
    );

    pfd_drive u_drive (
        .ref_seen (ref_seen),
        .vco_seen (vco_seen),
        .se_o     (se),
        .phi_r_n  (phi_r_n),
        .phi_v_n  (phi_v_n),
        .lock_o   (lock)
    );

    // unpack the single-ended output
    always_comb begin
        pd_drive = se.drive;
        pd_oe    = se.oe;
    end

    // R2
    neg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_oe && !pd_drive) |-> (!phi_v_n && phi_r_n));
    // R3
    pos_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_oe && pd_drive) |-> (!phi_r_n && phi_v_n));
    // R4
    coincident_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!phi_r_n && !phi_v_n) |-> !pd_oe);
    // R7
    lock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock |-> pd_oe);
    // R8
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (phi_r_n && phi_v_n && !pd_oe && lock));
endmodule

// File: tb/pfd_lock_top_tb.sv
module pfd_lock_top_tb;
    localparam int CLK_NS = 10;
    localparam int SYNC   = 2;
    localparam int MINP   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic vco_in = 1'b0;
    logic pd_drive, pd_oe, phi_r_n, phi_v_n, lock;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // model state
    logic [SYNC:0] mr, mv;
    logic mf_r, mf_v;
    int   mcnt;

    // per-case tallies
    int cnt_hi, cnt_lo, cnt_both, cnt_unlock;
    int run_oe, runs_oe, min_oe, max_oe;
    int run_bo, runs_bo, min_bo, max_bo;

    always #(CLK_NS/2) clk = ~clk;

    pfd_lock_top #(.SYNC_STAGES(SYNC), .MIN_PULSE(MINP)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .vco_in(vco_in),
        .pd_drive(pd_drive), .pd_oe(pd_oe), .phi_r_n(phi_r_n),
        .phi_v_n(phi_v_n), .lock(lock)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // one rising clock edge of the requirement model
    task automatic model_edge(input logic r, input logic v, input logic rs);
        logic er, ev;
        er = mr[SYNC-1] & ~mr[SYNC];
        ev = mv[SYNC-1] & ~mv[SYNC];
        if (!rs) begin
            mr = '0; mv = '0; mf_r = 1'b0; mf_v = 1'b0; mcnt = 0;
        end else begin
            if (mf_r && mf_v) begin
                if (mcnt == MINP - 1) begin
                    mf_r = er; mf_v = ev; mcnt = 0;
                end else begin
                    mcnt++;
                end
            end else begin
                mf_r = mf_r | er; mf_v = mf_v | ev; mcnt = 0;
            end
            mr = {mr[SYNC-1:0], r};
            mv = {mv[SYNC-1:0], v};
        end
    endtask

    task automatic clear_tally();
        cnt_hi = 0; cnt_lo = 0; cnt_both = 0; cnt_unlock = 0;
        run_oe = 0; runs_oe = 0; min_oe = 1000000; max_oe = 0;
        run_bo = 0; runs_bo = 0; min_bo = 1000000; max_bo = 0;
    endtask

    // compare outputs against model and update tallies
    task automatic sample();
        logic e_oe;
        e_oe = mf_r ^ mf_v;
        chk(phi_r_n == !mf_r, "R3 phi_r_n", int'(phi_r_n), int'(!mf_r));
        chk(phi_v_n == !mf_v, "R2 phi_v_n", int'(phi_v_n), int'(!mf_v));
        chk(pd_oe == e_oe, "R2 pd_oe", int'(pd_oe), int'(e_oe));
        if (e_oe)
            chk(pd_drive == mf_r, "R3 pd_drive", int'(pd_drive), int'(mf_r));
        chk(lock == !e_oe, "R7 lock", int'(lock), int'(!e_oe));
        if (pd_oe && pd_drive) cnt_hi++;
        if (pd_oe && !pd_drive) cnt_lo++;
        if (!lock) cnt_unlock++;
        if (pd_oe) run_oe++;
        else if (run_oe > 0) begin
            runs_oe++;
            if (runs_oe > 2) begin
                if (run_oe < min_oe) min_oe = run_oe;
                if (run_oe > max_oe) max_oe = run_oe;
            end
            run_oe = 0;
        end
        if (!phi_r_n && !phi_v_n) begin
            cnt_both++; run_bo++;
        end else if (run_bo > 0) begin
            runs_bo++;
            if (runs_bo > 1) begin
                if (run_bo < min_bo) min_bo = run_bo;
                if (run_bo > max_bo) max_bo = run_bo;
            end
            run_bo = 0;
        end
    endtask

    // negedge: check, then drive the next inputs and advance the model
    task automatic step(input logic r, input logic v, input logic rs);
        @(negedge clk);
        sample();
        ref_in = r; vco_in = v; rst_n = rs;
        model_edge(r, v, rs);
    endtask

    task automatic do_reset();
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1);
    endtask

    function automatic logic wave(input int t, input int per, input int off);
        return ((t + off) % per) < (per / 2);
    endfunction

    task automatic run_wave(input int pr, input int pv, input int off, input int ncyc);
        do_reset();
        clear_tally();
        for (int t = 0; t < ncyc; t++) step(wave(t, pr, 0), wave(t, pv, off), 1'b1);
    endtask

    initial begin
        mr = '0; mv = '0; mf_r = 1'b0; mf_v = 1'b0; mcnt = 0;
        clear_tally();
        void'($urandom(32'd1357));

        // R8 reset state
        do_reset();
        @(negedge clk);
        chk(phi_r_n && phi_v_n, "R8 phi pair high", int'({phi_r_n, phi_v_n}), 3);
        chk(!pd_oe, "R8 high impedance", int'(pd_oe), 0);
        chk(lock, "R8 lock high", int'(lock), 1);

        // R1 latency: reference edge shows on the third clock edge
        step(1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b1);
        chk(phi_r_n == 1'b1, "R1 not yet after two edges", int'(phi_r_n), 1);
        step(1'b1, 1'b0, 1'b1);
        chk(phi_r_n == 1'b0, "R1 set on third edge", int'(phi_r_n), 0);
        chk(pd_oe && pd_drive, "R3 positive drive", int'({pd_oe, pd_drive}), 3);
        // R9 extra reference edge while flag set has no effect
        step(1'b0, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1);
        clear_tally();
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 1'b1);
        chk(cnt_both == 0 && !pd_oe, "R9 stale edge ignored", cnt_both, 0);

        // R2 oscillator faster
        run_wave(40, 30, 0, 1200);
        chk(cnt_lo > 0, "R2 negative pulses present", cnt_lo, 1);
        chk(cnt_hi == 0, "R2 no positive pulses", cnt_hi, 0);
        chk(cnt_unlock > 0, "R7 lock drops out of lock", cnt_unlock, 1);

        // R3 oscillator slower
        run_wave(30, 40, 0, 1200);
        chk(cnt_hi > 0, "R3 positive pulses present", cnt_hi, 1);
        chk(cnt_lo == 0, "R3 no negative pulses", cnt_lo, 0);

        // R4 R5 in lock
        run_wave(32, 32, 0, 800);
        chk(cnt_hi + cnt_lo == 0, "R4 stays high impedance", cnt_hi + cnt_lo, 0);
        chk(cnt_both > 0, "R4 coincident pulses present", cnt_both, 1);
        chk(cnt_unlock == 0, "R7 lock stays high", cnt_unlock, 0);
        chk(min_bo == MINP && max_bo == MINP, "R5 coincident width", min_bo, MINP);

        // R6 oscillator leads by d clocks at equal frequency
        for (int d = 1; d <= 6; d += 5) begin
            run_wave(24, 24, d, 600);
            chk(cnt_hi == 0, "R6 lead gives no positive pulse", cnt_hi, 0);
            chk(min_oe == d && max_oe == d, "R6 pulse width", max_oe, d);
        end

        // R9 random drifting cases against the model
        for (int k = 0; k < 24; k++) begin
            int pr, pv, off;
            pr  = 10 + int'($urandom_range(0, 40));
            pv  = pr + int'($urandom_range(0, 6)) - 3;
            off = int'($urandom_range(0, 40));
            run_wave(pr, pv, off, 700);
        end
        chk(n_bad == 0, "R9 random drift model match", n_bad, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule